// File: doc/BRIEF.md
# Store Buffer with Load Bypass and Fences

This block sits between one processor's memory pipeline and its memory port and relaxes only the write-then-read ordering. A store is taken into a small queue of address and data and the processor moves on at once. The queue writes its entries out to memory one at a time, oldest first. A later load may go to memory ahead of the waiting stores. The one exception is a load whose address equals that of an older queued store: it is held until every such store has been acknowledged. No value is ever forwarded from the queue to a load.

The processor side offers one operation per cycle on a valid/ready pair. An operation is a store, a load or one of three fences. A fence is simply not accepted until the operations it waits for have finished. It leaves no state behind after it is accepted. The memory side carries one request at a time. The request is held steady until a single-cycle acknowledge ends it.

Top module: `store_order_buffer`

## Requirements
- R1: While rst_ni is low, and right after it rises, the queue is empty and no load is pending: mem_req_o and rsp_valid_o are 0, and a store or a store fence is offered with op_ready_o = 1. A reset drops any queued stores without writing them.
- R2: Operation codes on op_kind_i: 0 store, 1 load, 2 load fence, 3 store fence, 4 full fence. A store is accepted in the cycle it is offered whenever fewer than DEPTH stores are queued, whatever the memory is doing.
- R3: With DEPTH stores queued (a store counts as queued until its write is acknowledged), op_ready_o is 0 for a store.
- R4: Stores are written to memory (mem_we_o = 1) in the exact order they were accepted, with the accepted address and data.
- R5: When the memory port is idle and a load is waiting with no conflicting older store, the load is requested before any queued store. A load to a fresh address therefore overtakes all queued stores except one already in flight.
- R6: A load is not requested while any store accepted before it to the same address is still queued. Stores accepted after the load never delay it. The data returned always equals the most recent earlier store to that address, or the prior memory content if there is none.
- R7: rsp_valid_o pulses for exactly one cycle, the cycle after a load's acknowledge, with rsp_data_o equal to mem_rdata_i at the acknowledge. Only one load is in progress at a time, and op_ready_o is 0 for a load while one is.
- R8: A load fence is accepted only when no load is in progress.
- R9: A store fence is accepted only when the queue is empty, which means every earlier store has been acknowledged.
- R10: A full fence is accepted only when both the R8 and R9 conditions hold.
- R11: Once mem_req_o is 1 it stays 1, with address, write flag and data unchanged, until the cycle mem_ack_i is 1. After that cycle it is 0 for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Processor offers an operation |
| op_kind_i | input | 3 | Operation code (see R2) |
| op_addr_i | input | AW | Address for store or load |
| op_wdata_i | input | DW | Store data |
| op_ready_o | output | 1 | Operation accepted this cycle |
| rsp_valid_o | output | 1 | Load data valid |
| rsp_data_o | output | DW | Load data |
| mem_req_o | output | 1 | Memory request active |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Request address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Single-cycle completion of the active request |
| mem_rdata_i | input | DW | Read data, valid with the acknowledge |

## Verification
The assertions assume that mem_ack_i is only raised while mem_req_o is 1 and lasts one cycle, and that mem_rdata_i is valid in that cycle. The bench memory model acknowledges only an active request, after a random delay of one to three cycles, and can hold off acknowledges entirely to build up a backlog. Processor operations are driven one at a time and held until accepted. Addresses are confined to a few values so that address conflicts and repeated stores to one location happen often.

// File: rtl/sob_pkg.sv
package sob_pkg;
  typedef enum logic [2:0] {
    OP_STORE  = 3'd0,
    OP_LOAD   = 3'd1,
    OP_LFENCE = 3'd2,
    OP_SFENCE = 3'd3,
    OP_MFENCE = 3'd4
  } op_kind_e;

  typedef enum logic [1:0] {
    LS_IDLE = 2'd0,
    LS_WAIT = 2'd1,
    LS_MEM  = 2'd2
  } ld_state_e;
endpackage

// File: rtl/sob_queue.sv
module sob_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [AW-1:0]    push_addr_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  input  logic [AW-1:0]    look_addr_i,
  output logic             full_o,
  output logic             empty_o,
  output logic [AW-1:0]    head_addr_o,
  output logic [DW-1:0]    head_data_o,
  output logic [DEPTH-1:0] valid_o,
  output logic [DEPTH-1:0] match_o,
  output logic [DEPTH-1:0] pop_vec_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o      = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];
  assign valid_o     = valid_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign match_o[i]   = valid_q[i] && (addr_q[i] == look_addr_i);
    assign pop_vec_o[i] = pop_i && (rd_ptr_q == PW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end else if (push_i && (wr_ptr_q == PW'(i))) begin
        addr_q[i] <= push_addr_i;
        data_q[i] <= push_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) begin
        valid_q[wr_ptr_q] <= 1'b1;
        wr_ptr_q          <= ptr_inc(wr_ptr_q);
      end
      if (pop_i) begin
        valid_q[rd_ptr_q] <= 1'b0;
        rd_ptr_q          <= ptr_inc(rd_ptr_q);
      end
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r3_count_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_q) == int'(cnt_q));
endmodule

// File: rtl/sob_load_slot.sv
module sob_load_slot
  import sob_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DEPTH-1:0] q_valid_i,
  input  logic [DEPTH-1:0] q_match_i,
  input  logic [DEPTH-1:0] q_pop_i,
  input  logic             issue_i,
  input  logic             done_i,
  input  logic [DW-1:0]    rdata_i,
  output logic             idle_o,
  output logic             want_o,
  output logic             conflict_o,
  output logic [AW-1:0]    addr_o,
  output logic             rsp_valid_o,
  output logic [DW-1:0]    rsp_data_o
);
  ld_state_e        state_q;
  logic [DEPTH-1:0] older_q;

  // only stores queued before the load may block it
  assign conflict_o = |(older_q & q_match_i);
  assign idle_o     = (state_q == LS_IDLE);
  assign want_o     = (state_q == LS_WAIT) && !conflict_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= LS_IDLE;
      older_q     <= '0;
      addr_o      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      older_q     <= older_q & ~q_pop_i;
      case (state_q)
        LS_IDLE: if (accept_i) begin
          state_q <= LS_WAIT;
          addr_o  <= addr_i;
          older_q <= q_valid_i & ~q_pop_i;
        end
        LS_WAIT: if (issue_i) state_q <= LS_MEM;
        LS_MEM: if (done_i) begin
          state_q     <= LS_IDLE;
          rsp_valid_o <= 1'b1;
          rsp_data_o  <= rdata_i;
        end
        default: state_q <= LS_IDLE;
      endcase
    end
  end

  a_r6_issue_only_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (state_q == LS_WAIT) && !conflict_o);
  a_r7_rsp_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(done_i));
  a_r7_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> idle_o);
endmodule

// File: rtl/sob_mem_port.sv
module sob_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_want_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          st_avail_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          mem_ack_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          ld_issue_o,
  output logic          ld_done_o,
  output logic          st_done_o
);
  logic st_issue;

  // load wins over store drain
  assign ld_issue_o = !mem_req_o && ld_want_i;
  assign st_issue   = !mem_req_o && !ld_want_i && st_avail_i;
  assign ld_done_o  = mem_req_o && mem_ack_i && !mem_we_o;
  assign st_done_o  = mem_req_o && mem_ack_i && mem_we_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else if (mem_req_o) begin
      if (mem_ack_i) mem_req_o <= 1'b0;
    end else if (ld_issue_o) begin
      mem_req_o  <= 1'b1;
      mem_we_o   <= 1'b0;
      mem_addr_o <= ld_addr_i;
    end else if (st_issue) begin
      mem_req_o   <= 1'b1;
      mem_we_o    <= 1'b1;
      mem_addr_o  <= st_addr_i;
      mem_wdata_o <= st_data_i;
    end
  end

  a_r11_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                               && $stable(mem_we_o) && $stable(mem_wdata_o));
  a_r11_gap_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o);
  a_r5_load_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_want_i && !mem_req_o |=> mem_req_o && !mem_we_o);
endmodule

// File: rtl/store_order_buffer.sv
module store_order_buffer
  import sob_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [2:0]    op_kind_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [DW-1:0] op_wdata_i,
  output logic          op_ready_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic             q_full, q_empty, q_pop;
  logic [AW-1:0]    q_head_addr, ld_addr;
  logic [DW-1:0]    q_head_data;
  logic [DEPTH-1:0] q_valid, q_match, q_pop_vec;
  logic             ld_idle, ld_want, ld_conflict, ld_issue, ld_done;
  logic             st_push, ld_accept, take;

  always_comb begin
    case (op_kind_i)
      OP_STORE:  op_ready_o = !q_full;
      OP_LOAD:   op_ready_o = ld_idle;
      OP_LFENCE: op_ready_o = ld_idle;
      OP_SFENCE: op_ready_o = q_empty;
      OP_MFENCE: op_ready_o = ld_idle && q_empty;
      default:   op_ready_o = 1'b1;
    endcase
  end

  assign take      = op_valid_i && op_ready_o;
  assign st_push   = take && (op_kind_i == OP_STORE);
  assign ld_accept = take && (op_kind_i == OP_LOAD);

  sob_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk_i, .rst_ni,
    .push_i(st_push), .push_addr_i(op_addr_i), .push_data_i(op_wdata_i),
    .pop_i(q_pop), .look_addr_i(ld_addr),
    .full_o(q_full), .empty_o(q_empty),
    .head_addr_o(q_head_addr), .head_data_o(q_head_data),
    .valid_o(q_valid), .match_o(q_match), .pop_vec_o(q_pop_vec)
  );

  sob_load_slot #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_load (
    .clk_i, .rst_ni,
    .accept_i(ld_accept), .addr_i(op_addr_i),
    .q_valid_i(q_valid), .q_match_i(q_match), .q_pop_i(q_pop_vec),
    .issue_i(ld_issue), .done_i(ld_done), .rdata_i(mem_rdata_i),
    .idle_o(ld_idle), .want_o(ld_want), .conflict_o(ld_conflict),
    .addr_o(ld_addr), .rsp_valid_o, .rsp_data_o
  );

  sob_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i, .rst_ni,
    .ld_want_i(ld_want), .ld_addr_i(ld_addr),
    .st_avail_i(!q_empty), .st_addr_i(q_head_addr), .st_data_i(q_head_data),
    .mem_ack_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .ld_issue_o(ld_issue), .ld_done_o(ld_done), .st_done_o(q_pop)
  );

  a_r6_no_older_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> !ld_conflict);
  a_r8_lfence_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_kind_i == OP_LFENCE) |-> !(mem_req_o && !mem_we_o));
  a_r9_sfence_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_kind_i == OP_SFENCE) |-> !(mem_req_o && mem_we_o));
  a_r10_mfence_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_kind_i == OP_MFENCE) |-> !mem_req_o);
endmodule

// File: tb/sim_store_order_buffer.sv
module sim_store_order_buffer;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int AW    = 32;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          op_valid_i = 1'b0;
  logic [2:0]    op_kind_i = '0;
  logic [AW-1:0] op_addr_i = '0;
  logic [DW-1:0] op_wdata_i = '0;
  logic          op_ready_o, rsp_valid_o, mem_req_o, mem_we_o;
  logic [DW-1:0] rsp_data_o, mem_wdata_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_ack_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;

  store_order_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni, .op_valid_i, .op_kind_i, .op_addr_i, .op_wdata_i,
    .op_ready_o, .rsp_valid_o, .rsp_data_o, .mem_req_o, .mem_we_o,
    .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // bench model
  logic [DW-1:0] memarr [16];
  logic [DW-1:0] shadow [16];
  logic [AW-1:0] q_addr [1024];
  logic [DW-1:0] q_data [1024];
  int            q_seq  [1024];
  int qh = 0, qt = 0, seq = 0, st_pend = 0, writes = 0, ld_req_writes = 0;
  bit ld_out = 0, hold = 0;
  logic [DW-1:0] ld_exp = '0;
  int ld_seq = 0, wait_cnt = 0, lat = 1;
  bit prev_req = 0, prev_we = 0, acked = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_data = '0;
  bit cur_we = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_data = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ready(input logic [2:0] k);
    case (k)
      3'd0: return st_pend < DEPTH;
      3'd1: return !ld_out;
      3'd2: return !ld_out;
      3'd3: return st_pend == 0;
      3'd4: return !ld_out && st_pend == 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string kind_req(input logic [2:0] k);
    case (k)
      3'd0: return (st_pend < DEPTH) ? "R2" : "R3";
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      default: return "R10";
    endcase
  endfunction

  // memory model and output monitor
  always @(negedge clk) begin
    if (!rst_ni) begin
      mem_ack_i = 0; prev_req = 0; acked = 0; wait_cnt = 0;
    end else begin
      if (mem_ack_i) begin
        if (cur_we) begin
          chk(qh < qt, "R4", "unexpected write", 64'(cur_addr), 0);
          if (qh < qt) begin
            chk(cur_addr == q_addr[qh], "R4", "write addr", 64'(cur_addr), 64'(q_addr[qh]));
            chk(cur_data == q_data[qh], "R4", "write data", 64'(cur_data), 64'(q_data[qh]));
            qh++;
          end
          memarr[cur_addr[3:0]] = cur_data;
          st_pend--; writes++;
        end else begin
          chk(rsp_valid_o == 1'b1, "R7", "rsp_valid after ack", 64'(rsp_valid_o), 1);
          chk(rsp_data_o == ld_exp, "R6", "load data", 64'(rsp_data_o), 64'(ld_exp));
          ld_out = 0;
        end
        mem_ack_i = 0;
      end else begin
        chk(rsp_valid_o == 1'b0, "R7", "spurious rsp_valid", 64'(rsp_valid_o), 0);
      end
      if (prev_req && !acked) begin
        chk(mem_req_o && mem_we_o == prev_we && mem_addr_o == prev_addr &&
            (!prev_we || mem_wdata_o == prev_data), "R11", "request not held",
            64'(mem_req_o), 1);
      end
      if (acked) chk(!mem_req_o, "R11", "no gap after ack", 64'(mem_req_o), 0);
      acked = 0;
      if (mem_req_o && !prev_req) begin
        wait_cnt = 0;
        lat = $urandom_range(1, 3);
        if (!mem_we_o) begin
          ld_req_writes = writes;
          for (int i = qh; i < qt; i++)
            if (q_seq[i] < ld_seq && q_addr[i] == mem_addr_o)
              chk(0, "R6", "load passed older match", 64'(mem_addr_o), 64'(q_addr[i]));
        end
      end
      if (mem_req_o) begin
        wait_cnt++;
        if (!hold && wait_cnt >= lat) begin
          mem_ack_i = 1; acked = 1;
          cur_we = mem_we_o; cur_addr = mem_addr_o; cur_data = mem_wdata_o;
          mem_rdata_i = memarr[mem_addr_o[3:0]];
        end
      end
      prev_req = mem_req_o; prev_we = mem_we_o;
      prev_addr = mem_addr_o; prev_data = mem_wdata_o;
    end
  end

  task automatic issue(input logic [2:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); #1;
    op_valid_i = 1; op_kind_i = k; op_addr_i = a; op_wdata_i = d;
    forever begin
      chk(op_ready_o == exp_ready(k), kind_req(k), "op_ready", 64'(op_ready_o), 64'(exp_ready(k)));
      if (op_ready_o) break;
      @(negedge clk); #1;
    end
    @(posedge clk);
    if (k == 3'd0) begin
      q_addr[qt] = a; q_data[qt] = d; q_seq[qt] = seq; qt++;
      shadow[a[3:0]] = d; st_pend++;
    end else if (k == 3'd1) begin
      ld_out = 1; ld_exp = shadow[a[3:0]]; ld_seq = seq;
    end
    seq++;
    #1 op_valid_i = 0;
  endtask

  task automatic probe(input logic [2:0] k, input bit exp, input string req);
    @(negedge clk); #1;
    op_valid_i = 1; op_kind_i = k;
    chk(op_ready_o == exp, req, "probe ready", 64'(op_ready_o), 64'(exp));
    #1 op_valid_i = 0;
  endtask

  task automatic wait_idle();
    while (st_pend != 0 || ld_out) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int base;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin memarr[i] = 32'h100 + i; shadow[i] = 32'h100 + i; end
    repeat (3) @(negedge clk);
    chk(mem_req_o == 0, "R1", "req in reset", 64'(mem_req_o), 0);
    rst_ni = 1;
    @(negedge clk); #1;
    chk(rsp_valid_o == 0, "R1", "rsp after reset", 64'(rsp_valid_o), 0);
    probe(3'd0, 1, "R1");
    probe(3'd3, 1, "R1");

    // fill queue while memory stalls
    hold = 1;
    for (int i = 0; i < DEPTH; i++) issue(3'd0, AW'(i + 1), DW'(32'hA0 + i));
    probe(3'd0, 0, "R3");
    probe(3'd3, 0, "R9");
    probe(3'd4, 0, "R10");
    hold = 0;
    wait_idle();

    // load to fresh address overtakes queued stores
    hold = 1; base = writes;
    issue(3'd0, 1, 32'hB1); issue(3'd0, 2, 32'hB2); issue(3'd0, 3, 32'hB3);
    issue(3'd1, 9, 0);
    probe(3'd2, 0, "R8");
    repeat (3) @(negedge clk);
    hold = 0;
    wait_idle();
    chk(ld_req_writes - base == 1, "R5", "writes before bypass load", 64'(ld_req_writes - base), 1);

    // conflicting load waits for all older matches
    hold = 1; base = writes;
    issue(3'd0, 5, 32'hC1); issue(3'd0, 6, 32'hC2); issue(3'd0, 5, 32'hC3);
    issue(3'd1, 5, 0);
    issue(3'd0, 5, 32'hC4);
    repeat (3) @(negedge clk);
    hold = 0;
    wait_idle();
    chk(ld_req_writes - base == 3, "R6", "writes before held load", 64'(ld_req_writes - base), 3);

    // reset drops queued stores
    hold = 1;
    issue(3'd0, 7, 32'hD1); issue(3'd0, 8, 32'hD2);
    @(negedge clk); rst_ni = 0;
    @(negedge clk); @(negedge clk);
    qh = qt; st_pend = 0; ld_out = 0;
    for (int i = 0; i < 16; i++) shadow[i] = memarr[i];
    chk(mem_req_o == 0, "R1", "req after mid reset", 64'(mem_req_o), 0);
    rst_ni = 1; hold = 0;
    probe(3'd3, 1, "R1");
    repeat (4) @(negedge clk);
    chk(memarr[7] != 32'hD1, "R1", "dropped store written", 64'(memarr[7]), 0);

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r <= 4)      issue(3'd0, AW'($urandom_range(0, 7)), DW'($urandom));
      else if (r <= 7) issue(3'd1, AW'($urandom_range(0, 7)), 0);
      else if (r == 8) issue(3'($urandom_range(2, 4)), 0, 0);
      else             @(negedge clk);
    end
    wait_idle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule